// File: doc/BRIEF.md
# Fault-Limiting Mode Transition Sequencer

This block decides, cycle by cycle, whether a series voltage restorer runs its inverter to compensate the line voltage or fires its anti-parallel thyristors so that the output filter is switched into the line as a current-limiting impedance. It watches a digitised line-current magnitude. When that magnitude stays above a trip level, it takes the inverter down first. Only after a programmable dead gap does it raise the thyristor trigger.

When the fault has gone, the current must fall below a separate, lower return level before the trigger is dropped. The inverter is not re-enabled on a timer. It waits until the thyristors report a natural turn-off: negative voltage across them together with a current-zero indication. A fault that comes back while the sequencer is waiting for turn-off sends it straight back to limiting. A 3-bit mode output reports the sequencer state.

Top module: `fault_mode_sequencer`

## Requirements
- R1: After reset the mode is NORMAL (code 0), `inv_en` is 1 and `thy_fire` is 0.
- R2: A trip is recognised only after `i_mag` is strictly greater than `trip_level` on TRIP_CNT consecutive clock samples. A shorter run of such samples changes neither the mode nor the outputs.
- R3: On the clock edge that samples the last of those consecutive trip samples, the mode becomes INV_OFF (code 1), `inv_en` drops to 0 and `thy_fire` stays 0.
- R4: The mode stays INV_OFF for exactly GAP_CYC cycles and then becomes LIMITING (code 2) with `thy_fire` 1 and `inv_en` 0. `inv_en` and `thy_fire` are never both 1.
- R5: Once LIMITING is entered, it lasts at least HOLD_CYC cycles, whatever the current does.
- R6: LIMITING is left only when `i_mag` is strictly below `return_level`. The mode then becomes RELEASE (code 3) with `thy_fire` 0 for one cycle, followed by WAIT_OFF (code 4). A magnitude equal to `return_level` keeps LIMITING.
- R7: WAIT_OFF moves to RESTART (code 5) only on a sample where `thy_izero` and `thy_vneg` are both 1. RESTART lasts one cycle with `inv_en` 1 and is followed by NORMAL.
- R8: A recognised trip (as in R2) during RELEASE or WAIT_OFF returns the sequencer to LIMITING with `thy_fire` 1 and a fresh HOLD_CYC minimum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| i_mag | input | MAG_W | Line-current magnitude sample |
| trip_level | input | MAG_W | Trip threshold for the magnitude |
| return_level | input | MAG_W | Release threshold (set above the normal load peak) |
| thy_izero | input | 1 | Thyristor current is below holding level |
| thy_vneg | input | 1 | Voltage across the thyristors is negative |
| inv_en | output | 1 | Inverter switching enable |
| thy_fire | output | 1 | Thyristor trigger command |
| mode | output | 3 | Current sequencer state code |

## Verification
The sequencer is driven first with short over-threshold bursts that are one sample too brief. This separates a real consecutive-sample filter from a plain comparator. A full fault is then applied and held, showing the exact dead gap and a limiting phase that persists while the current stays high. A second fault is applied and dropped at once, which exposes the minimum hold time. The release path gets magnitudes between the two thresholds and exactly at the return level, thyristor indications with only one of the two conditions true, and a fault that returns during WAIT_OFF. These show whether release, restart and re-trip are gated by the right conditions.

// File: rtl/fms_pkg.sv
package fms_pkg;
  typedef enum logic [2:0] {
    ST_NORMAL   = 3'd0,
    ST_INV_OFF  = 3'd1,
    ST_LIMITING = 3'd2,
    ST_RELEASE  = 3'd3,
    ST_WAIT_OFF = 3'd4,
    ST_RESTART  = 3'd5
  } seq_state_t;
endpackage

// File: rtl/fms_trip_filter.sv
module fms_trip_filter #(
  parameter int MAG_W    = 12,
  parameter int TRIP_CNT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [MAG_W-1:0] mag,
  input  logic [MAG_W-1:0] level,
  output logic             trip
);
  localparam int FW = $clog2(TRIP_CNT + 1);
  localparam logic [FW-1:0] SAT = FW'(TRIP_CNT);
  localparam logic [FW-1:0] ARM = FW'(TRIP_CNT - 1);

  logic          over;
  logic [FW-1:0] run_q, run_d;

  assign over = (mag > level);

  always_comb begin
    if (!over)
      run_d = '0;
    else if (run_q != SAT)
      run_d = run_q + 1'b1;
    else
      run_d = run_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_d;
  end

  assign trip = over && (run_q >= ARM);

  assert_run_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= SAT);
  assert_run_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !over |=> run_q == '0);
endmodule

// File: rtl/fms_timer.sv
module fms_timer #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);
  logic [TW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = load || (cnt_q != '0);

  always_comb begin
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

  assert_timer_loads_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt_q == $past(load_val));
endmodule

// File: rtl/fault_mode_sequencer.sv
module fault_mode_sequencer
  import fms_pkg::*;
#(
  parameter int MAG_W    = 12,
  parameter int TRIP_CNT = 3,
  parameter int GAP_CYC  = 4,
  parameter int HOLD_CYC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [MAG_W-1:0] i_mag,
  input  logic [MAG_W-1:0] trip_level,
  input  logic [MAG_W-1:0] return_level,
  input  logic             thy_izero,
  input  logic             thy_vneg,
  output logic             inv_en,
  output logic             thy_fire,
  output logic [2:0]       mode
);
  localparam int TMAX = (GAP_CYC > HOLD_CYC) ? GAP_CYC : HOLD_CYC;
  localparam int TW   = $clog2(TMAX + 1);
  localparam logic [TW-1:0] GAP_LD  = TW'(GAP_CYC - 1);
  localparam logic [TW-1:0] HOLD_LD = TW'(HOLD_CYC - 1);

  seq_state_t    state_q, state_d;
  logic          trip;
  logic          tmr_load;
  logic [TW-1:0] tmr_val;
  logic          tmr_done;
  logic          below_ret;
  logic          thy_off;

  fms_trip_filter #(.MAG_W(MAG_W), .TRIP_CNT(TRIP_CNT)) u_filter (
    .clk(clk), .rst_n(rst_n), .mag(i_mag), .level(trip_level), .trip(trip)
  );

  fms_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .expired(tmr_done)
  );

  assign below_ret = (i_mag < return_level);
  assign thy_off   = thy_izero && thy_vneg;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = HOLD_LD;
    case (state_q)
      ST_NORMAL: if (trip) begin
        state_d  = ST_INV_OFF;
        tmr_load = 1'b1;
        tmr_val  = GAP_LD;
      end
      ST_INV_OFF: if (tmr_done) begin
        state_d  = ST_LIMITING;
        tmr_load = 1'b1;
      end
      ST_LIMITING: if (tmr_done && below_ret) state_d = ST_RELEASE;
      ST_RELEASE: begin
        if (trip) begin
          state_d  = ST_LIMITING;
          tmr_load = 1'b1;
        end else begin
          state_d = ST_WAIT_OFF;
        end
      end
      ST_WAIT_OFF: begin
        if (trip) begin
          state_d  = ST_LIMITING;
          tmr_load = 1'b1;
        end else if (thy_off) begin
          state_d = ST_RESTART;
        end
      end
      ST_RESTART: state_d = ST_NORMAL;
      default:    state_d = ST_NORMAL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_NORMAL;
    else        state_q <= state_d;
  end

  assign inv_en   = (state_q == ST_NORMAL) || (state_q == ST_RESTART);
  assign thy_fire = (state_q == ST_LIMITING);
  assign mode     = state_q;

  assert_interlock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(inv_en && thy_fire));
  assert_fire_after_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(thy_fire) |-> !$past(inv_en));
  assert_trip_kills_inv_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_NORMAL && trip) |=> !inv_en);
  assert_release_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LIMITING && !below_ret) |=> thy_fire);
  assert_restart_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(inv_en) |-> $past(thy_izero && thy_vneg));
  assert_retrip_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT_OFF && trip) |=> thy_fire);
  assert_legal_mode_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mode <= 3'd5);
endmodule

// File: tb/fault_mode_sequencer_test.sv
module fault_mode_sequencer_test;
  localparam int MW = 12;

  typedef struct {
    logic [2:0] mode;
    logic       inv;
    logic       fire;
    string      tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [MW-1:0] i_mag;
  logic [MW-1:0] trip_level;
  logic [MW-1:0] return_level;
  logic          thy_izero, thy_vneg;
  logic          inv_en, thy_fire;
  logic [2:0]    mode;

  int   checks = 0;
  int   failures = 0;
  bit   done = 0;
  exp_t sb[$];

  always #4 clk = ~clk;

  fault_mode_sequencer #(.MAG_W(MW), .TRIP_CNT(3), .GAP_CYC(4), .HOLD_CYC(8)) uut (
    .clk(clk), .rst_n(rst_n), .i_mag(i_mag), .trip_level(trip_level),
    .return_level(return_level), .thy_izero(thy_izero), .thy_vneg(thy_vneg),
    .inv_en(inv_en), .thy_fire(thy_fire), .mode(mode)
  );

  // Expected outputs derived from the mode codes of R1, R4, R7
  task automatic push(input logic [2:0] m, input string tag);
    exp_t e;
    e.mode = m;
    e.inv  = (m == 3'd0) || (m == 3'd5);
    e.fire = (m == 3'd2);
    e.tag  = tag;
    sb.push_back(e);
  endtask

  task automatic cyc(input int mag, input logic iz, input logic vn,
                     input logic [2:0] m, input string tag);
    @(negedge clk);
    i_mag = MW'(mag); thy_izero = iz; thy_vneg = vn;
    push(m, tag);
  endtask

  always @(posedge clk) begin
    #2;
    if (sb.size() != 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (mode !== e.mode || inv_en !== e.inv || thy_fire !== e.fire) begin
        failures++;
        $display("FAIL %s: mode=%0d inv_en=%0b fire=%0b expected mode=%0d inv_en=%0b fire=%0b",
                 e.tag, mode, inv_en, thy_fire, e.mode, e.inv, e.fire);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; i_mag = '0; trip_level = MW'(1000); return_level = MW'(600);
    thy_izero = 1'b0; thy_vneg = 1'b0;
    repeat (3) @(negedge clk);
    checks++;
    if (mode !== 3'd0 || inv_en !== 1'b1 || thy_fire !== 1'b0) begin
      failures++;
      $display("FAIL R1 reset: mode=%0d inv=%0b fire=%0b expected 0 1 0", mode, inv_en, thy_fire);
    end
    rst_n = 1'b1;
    cyc(100, 0, 0, 3'd0, "R1 idle");

    // R2: two-sample bursts, and a value equal to the level, never trip
    cyc(1200, 0, 0, 3'd0, "R2 burst a1");
    cyc(1200, 0, 0, 3'd0, "R2 burst a2");
    cyc(100,  0, 0, 3'd0, "R2 gap");
    cyc(1200, 0, 0, 3'd0, "R2 burst b1");
    cyc(1000, 0, 0, 3'd0, "R2 equal level");
    cyc(1200, 0, 0, 3'd0, "R2 burst c1");
    cyc(1200, 0, 0, 3'd0, "R2 burst c2");
    // R3: third consecutive sample trips
    cyc(1200, 0, 0, 3'd1, "R3 trip");
    // R4: exactly four samples in INV_OFF
    for (int i = 0; i < 3; i++) cyc(1200, 0, 0, 3'd1, "R4 gap");
    cyc(1200, 0, 0, 3'd2, "R4 fire");
    // R5/R6: fault persists, then between thresholds, then equal to return
    for (int i = 0; i < 10; i++) cyc(1200, 0, 0, 3'd2, "R5 fault held");
    for (int i = 0; i < 3; i++) cyc(700, 0, 0, 3'd2, "R6 between levels");
    cyc(600, 0, 0, 3'd2, "R6 equal return");
    cyc(599, 0, 0, 3'd3, "R6 release");
    cyc(300, 0, 0, 3'd4, "R6 wait_off");
    // R7: one-sided indications do not restart
    cyc(300, 0, 0, 3'd4, "R7 none");
    cyc(300, 1, 0, 3'd4, "R7 izero only");
    cyc(300, 0, 1, 3'd4, "R7 vneg only");
    cyc(300, 1, 1, 3'd5, "R7 restart");
    cyc(300, 0, 0, 3'd0, "R7 normal");

    // R5: second fault dropped at once, hold must keep LIMITING 8 samples
    cyc(1200, 0, 0, 3'd0, "R5 trip a");
    cyc(1200, 0, 0, 3'd0, "R5 trip b");
    cyc(1200, 0, 0, 3'd1, "R5 trip c");
    for (int i = 0; i < 3; i++) cyc(100, 0, 0, 3'd1, "R4 gap again");
    cyc(100, 0, 0, 3'd2, "R5 limit start");
    for (int i = 0; i < 7; i++) cyc(100, 0, 0, 3'd2, "R5 min hold");
    cyc(100, 0, 0, 3'd3, "R5 release after hold");
    cyc(100, 0, 0, 3'd4, "R6 wait_off 2");

    // R8: fault returns while waiting for turn-off
    cyc(1200, 0, 0, 3'd4, "R8 retrip 1");
    cyc(1200, 0, 0, 3'd4, "R8 retrip 2");
    cyc(1200, 0, 0, 3'd2, "R8 back to limiting");
    for (int i = 0; i < 7; i++) cyc(100, 1, 1, 3'd2, "R8 fresh hold");
    cyc(100, 1, 1, 3'd3, "R8 release");
    cyc(100, 1, 1, 3'd4, "R8 wait_off");
    cyc(100, 1, 1, 3'd5, "R8 restart");
    cyc(100, 0, 0, 3'd0, "R8 normal");

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule